// File: doc/BRIEF.md
# Phase-Accumulator Clock Synthesizer

This block makes a square-wave clock of adjustable frequency from a fixed reference clock (24 MHz in the intended system). On every reference edge a tuning word is added to an N-bit phase register, which wraps modulo 2^N. The register's top bit, registered once more, is driven out as the synthesized clock. The output frequency is `f_ref * tw / 2^N`, so the frequency step is uniform and equals `f_ref / 2^N`. With N = 25 that step is about 0.715 Hz. N = 15 is the smallest width that still reaches 1 kHz.

The tuning word is written at run time through a data input and a one-cycle load pulse. A new word changes the frequency at once. The phase register is not restarted when the word changes, and no rebuild of the design is needed.

Every output edge lands on a reference edge, so peak-to-peak period jitter is one reference period (about 42 ns at 24 MHz). For logic that stays in the reference domain, the block also gives a one-cycle strobe on each rising output edge, which can be used as a clock enable.

Top module: `dds_clk_synth`

## Requirements
- R1: When `rst` is high at a clock edge, the phase register, the tuning register, `clk_out` and `rise_stb` are all cleared to 0 at that edge. A load pulse during reset is ignored.
- R2: On each edge with `rst` low, the phase register advances by the tuning register modulo 2^N. `clk_out` is the phase MSB delayed by one register stage. In any window of 2^N consecutive cycles of steady operation, `clk_out` has exactly as many rising edges as the tuning value in effect.
- R3: A tuning word written with bit N-1 set (value at or above 2^(N-1)) is stored as 2^(N-1)-1. This keeps the output below half the reference rate.
- R4: `tw_in` is captured into the tuning register only at an edge where `tw_load` is high. A change on `tw_in` without a load pulse has no effect on the output frequency.
- R5: Loading a new tuning word does not clear the phase register. Phase continues from its current value.
- R6: With a tuning value of 0, the phase register holds its value, so `clk_out` shows no edges.
- R7: `rise_stb` is high for exactly one cycle, in the same cycle that `clk_out` goes from 0 to 1. It is never high in any other cycle.
- R8: The spacing, in reference cycles, between two consecutive rising edges of `clk_out` differs from 2^N divided by the tuning value by less than one reference cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_load | input | 1 | One-cycle pulse that captures `tw_in` |
| tw_in | input | ACC_W | New frequency tuning word |
| clk_out | output | 1 | Synthesized clock (registered phase MSB) |
| rise_stb | output | 1 | One-cycle strobe on each `clk_out` rising edge |

## Verification
The bench builds the block with ACC_W = 10. At that width a full phase period lasts 1024 reference cycles, so each tuning value can be run over complete 2^N windows in which rising edges are counted exactly and every gap between edges is measured. The clamp boundary at 512 sits inside an ordinary test vector. Near the top of the range the output toggles almost every cycle, which stresses the one-cycle strobe. Freezing the phase mid-period with a zero load shows that a retune keeps the phase: after the freeze the output stays high, whereas a phase restart would leave it low.

// File: rtl/dds_clk_synth.sv
module dds_clk_synth #(
  parameter int ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tw_load,
  input  logic [ACC_W-1:0] tw_in,
  output logic             clk_out,
  output logic             rise_stb
);

  localparam logic [ACC_W-1:0] TW_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  logic [ACC_W-1:0] tw_q;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] tw_safe;
  logic             msb;

  assign tw_safe = tw_in[ACC_W-1] ? TW_MAX : tw_in;
  assign msb     = acc[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst)
      tw_q <= '0;
    else if (tw_load)
      tw_q <= tw_safe;
  end

  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else
      acc <= acc + tw_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_out  <= 1'b0;
      rise_stb <= 1'b0;
    end else begin
      clk_out  <= msb;
      rise_stb <= msb & ~clk_out;
    end
  end

endmodule

// File: rtl/dds_clk_synth_chk.sv
module dds_clk_synth_chk #(
  parameter int ACC_W = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             tw_load,
  input logic [ACC_W-1:0] tw_q,
  input logic [ACC_W-1:0] acc,
  input logic             clk_out,
  input logic             rise_stb
);

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!clk_out && !rise_stb && acc == '0 && tw_q == '0));

  p_tw_below_half_r3: assert property (@(posedge clk) disable iff (rst)
    !tw_q[ACC_W-1]);

  p_tw_held_r4: assert property (@(posedge clk) disable iff (rst)
    !tw_load |=> $stable(tw_q));

  p_zero_tw_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (tw_q == '0) |=> $stable(acc));

  p_stb_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> (clk_out && !$past(clk_out)));

  p_stb_single_r7: assert property (@(posedge clk) disable iff (rst)
    rise_stb |=> !rise_stb);

  p_rise_has_stb_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out) |-> rise_stb);

endmodule

bind dds_clk_synth dds_clk_synth_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tw_load  (tw_load),
  .tw_q     (tw_q),
  .acc      (acc),
  .clk_out  (clk_out),
  .rise_stb (rise_stb)
);

// File: tb/tb_dds_clk_synth.sv
module tb_dds_clk_synth;

  localparam int N      = 10;
  localparam int SPAN   = 1 << N;
  localparam int PERIOD = 10;
  localparam int NVEC   = 7;
  localparam int VEC [NVEC][2] = '{
    '{1, 1}, '{3, 3}, '{100, 100}, '{427, 427},
    '{511, 511}, '{600, 511}, '{1023, 511}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tw_load = 1'b0;
  logic [N-1:0] tw_in = '0;
  logic         clk_out;
  logic         rise_stb;

  int checks = 0;
  int errors = 0;
  int cnt_edges;
  int bad_gaps;

  always #(PERIOD/2) clk = ~clk;

  dds_clk_synth #(.ACC_W(N)) dut (
    .clk(clk), .rst(rst), .tw_load(tw_load), .tw_in(tw_in),
    .clk_out(clk_out), .rise_stb(rise_stb)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic load(input int v);
    tw_in = v[N-1:0]; tw_load = 1'b1;
    @(negedge clk);
    tw_load = 1'b0;
  endtask

  task automatic measure(input int tw);
    int gap;
    bit seen;
    cnt_edges = 0; bad_gaps = 0; gap = 0; seen = 0;
    for (int i = 0; i < SPAN; i++) begin
      @(negedge clk);
      gap++;
      if (rise_stb) begin
        cnt_edges++;
        if (seen && !((gap * tw > SPAN - tw) && (gap * tw < SPAN + tw)))
          bad_gaps++;
        seen = 1; gap = 0;
      end
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset state
    check("R1 clk_out in reset", clk_out, 0);
    check("R1 rise_stb in reset", rise_stb, 0);

    // R2 R3 R7 R8 table of tuning words and expected edge counts
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      load(VEC[v][0]);
      cyc(4);
      measure(VEC[v][1]);
      check($sformatf("R2/R3 edges tw=%0d", VEC[v][0]), cnt_edges, VEC[v][1]);
      check($sformatf("R8 gaps tw=%0d", VEC[v][0]), bad_gaps, 0);
    end

    // R6 zero tuning word: no edges, output low
    do_reset();
    load(0);
    cyc(2);
    measure(1);
    check("R6 edges with tw=0", cnt_edges, 0);
    check("R6 clk_out with tw=0", clk_out, 0);

    // R4 tw_in change without load is ignored
    do_reset();
    load(50);
    cyc(2);
    tw_in = 10'd300;
    cyc(4);
    measure(50);
    check("R4 edges after unloaded tw_in change", cnt_edges, 50);

    // R5 retune keeps phase: freeze at upper half, output stays high
    do_reset();
    load(128);
    begin
      int guard = 0;
      while (!rise_stb && guard < SPAN) begin
        @(negedge clk); guard++;
      end
    end
    load(0);
    cyc(2);
    check("R5 clk_out right after freeze", clk_out, 1);
    measure(1);
    check("R5 clk_out held high after retune", clk_out, 1);
    check("R5 no edges after freeze", cnt_edges, 0);

    // R1 mid-run reset clears outputs; load during reset ignored
    load(511);
    cyc(5);
    @(negedge clk); rst = 1'b1;
    tw_in = 10'd200; tw_load = 1'b1;
    @(negedge clk); tw_load = 1'b0;
    check("R1 clk_out after mid-run reset", clk_out, 0);
    check("R1 rise_stb after mid-run reset", rise_stb, 0);
    rst = 1'b0;
    cyc(3);
    measure(1);
    check("R1 load during reset ignored", cnt_edges, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule